// File: doc/BRIEF.md
# Loopback Stress First-Fail / All-Fail Recorder

This block watches IO loopback traffic while an external controller steps a stress setting (timing offset, voltage margin and the like) through a range. On each sampled cycle it compares the bits that were sent on a group of pins with the bits that came back. For each signal group it records two stress step values. The first is the step at which any pin of the group first failed. The second is the step by which every pin of the group had failed at least once. It also reports the distance between the two. A wide distance points to a pin with a local defect, while a narrow one points to the whole group running out of margin together.

The pins are split into `NUM_GROUPS` groups of `GROUP_W` pins. Group `g` uses bits `[g*GROUP_W +: GROUP_W]` of the expected and received vectors. Its results use the matching slices of the output vectors. Each group runs its own four-state controller. Those controllers share the start, clear, sample-valid and step inputs.

The group controller has four states. `ST_IDLE` means disarmed. `ST_WATCH` means armed with no pin failed. `ST_PARTIAL` means at least one pin failed but not all. `ST_DONE` means every pin failed. The transitions are:
- any state to `ST_IDLE` on clear;
- any state to `ST_WATCH` on start without clear;
- `ST_WATCH` to `ST_PARTIAL` on a sampled mismatch that leaves some pins unfailed;
- `ST_WATCH` or `ST_PARTIAL` to `ST_DONE` on a sampled cycle after which every pin has failed.

Otherwise the state holds.

Top module: `lb_fail_recorder`

## Requirements
- R1: After reset, all valid flags, step results, differences and pin fail bits read 0, and `run_active` is 0.
- R2: While a group is armed (`ST_WATCH` or `ST_PARTIAL`) and `smp_valid` is 1, any pin whose received bit differs from its expected bit gets its fail bit set in `pin_fail`. The bit stays set until clear or start.
- R3: On the first sampled cycle in which any pin of an armed group mismatches, that group's `first_vld` becomes 1 and `first_step` takes `step_in`. Neither changes again until clear or start.
- R4: On the sampled cycle after which every pin of the group has failed at least once, `all_vld` becomes 1 and `all_step` takes `step_in`. The group then enters `ST_DONE`, and later mismatches change none of its results.
- R5: `fail_delta` for a group equals `all_step - first_step` modulo 2^STEP_W when `all_vld` is 1. It is 0 when `all_vld` is 0.
- R6: Comparisons are ignored while `smp_valid` is 0 or while the group is in `ST_IDLE`.
- R7: Clear returns every group to `ST_IDLE` and zeroes its results and fail bits. Clear wins over a simultaneous start.
- R8: Start (without clear) zeroes previous results and fail bits and arms every group in `ST_WATCH`. `run_active` is 1 while any group is armed.
- R9: When the first and last pin failures fall in the same sampled cycle, `first_step` equals `all_step` and `fail_delta` is 0.
- R10: Groups are independent: mismatches in one group never change another group's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear results and arm all groups |
| clear_i | input | 1 | Clear results and disarm all groups |
| smp_valid | input | 1 | Compare this cycle |
| step_in | input | STEP_W | Current stress step value |
| exp_bits | input | NUM_GROUPS*GROUP_W | Transmitted pattern bits |
| rcv_bits | input | NUM_GROUPS*GROUP_W | Looped-back received bits |
| pin_fail | output | NUM_GROUPS*GROUP_W | Sticky per-pin fail bits |
| first_vld | output | NUM_GROUPS | First-fail recorded, one per group |
| first_step | output | NUM_GROUPS*STEP_W | First-fail step per group |
| all_vld | output | NUM_GROUPS | All-fail recorded, one per group |
| all_step | output | NUM_GROUPS*STEP_W | All-fail step per group |
| fail_delta | output | NUM_GROUPS*STEP_W | All-fail minus first-fail per group |
| run_active | output | 1 | Some group is armed |

## Verification
Every result is one register away from its stimulus. A comparison, start or clear applied before a clock edge shows on the outputs just after that edge. `fail_delta` is combinational from the two step registers and appears in the same cycle. The bench changes inputs one time unit after a rising edge, waits for the next rising edge, and samples one time unit later. Each check therefore reads exactly the cycle that the stimulus was meant to update.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WATCH   = 2'd1,
        ST_PARTIAL = 2'd2,
        ST_DONE    = 2'd3
    } grp_state_t;
endpackage

// File: rtl/lb_sticky.sv
module lb_sticky #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe_i,
    input  logic             cmp_en_i,
    input  logic [WIDTH-1:0] exp_i,
    input  logic [WIDTH-1:0] rcv_i,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] mask_nx
);
    logic [WIDTH-1:0] diff;

    assign diff    = exp_i ^ rcv_i;
    assign mask_nx = mask_q | diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wipe_i) begin
            mask_q <= '0;
        end else if (cmp_en_i) begin
            mask_q <= mask_nx;
        end
    end

    // R2: a set fail bit is never lost without a wipe
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe_i |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R7 / R8: wipe empties the mask
    a_r7_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (mask_q == '0));
endmodule

// File: rtl/lb_group_fsm.sv
module lb_group_fsm
    import lb_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic              smp_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [WIDTH-1:0]  mask_q,
    input  logic [WIDTH-1:0]  mask_nx,
    output logic              cmp_en_o,
    output logic              busy_o,
    output logic              first_vld_o,
    output logic [STEP_W-1:0] first_step_o,
    output logic              all_vld_o,
    output logic [STEP_W-1:0] all_step_o,
    output logic [STEP_W-1:0] delta_o
);
    grp_state_t state_q, state_d;
    logic       armed;
    logic       any_fail_nx;
    logic       full_fail_nx;

    assign armed        = (state_q == ST_WATCH) || (state_q == ST_PARTIAL);
    assign cmp_en_o     = armed && smp_i && !clear_i && !start_i;
    assign any_fail_nx  = |mask_nx;
    assign full_fail_nx = &mask_nx;
    assign busy_o       = armed;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_WATCH;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WATCH: begin
                    if (smp_i && full_fail_nx)
                        state_d = ST_DONE;
                    else if (smp_i && any_fail_nx)
                        state_d = ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (smp_i && full_fail_nx)
                        state_d = ST_DONE;
                end
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_vld_o  <= 1'b0;
            first_step_o <= '0;
            all_vld_o    <= 1'b0;
            all_step_o   <= '0;
        end else if (clear_i || start_i) begin
            first_vld_o  <= 1'b0;
            first_step_o <= '0;
            all_vld_o    <= 1'b0;
            all_step_o   <= '0;
        end else if (cmp_en_o) begin
            if (state_q == ST_WATCH && any_fail_nx) begin
                first_vld_o  <= 1'b1;
                first_step_o <= step_i;
            end
            if (full_fail_nx) begin
                all_vld_o  <= 1'b1;
                all_step_o <= step_i;
            end
        end
    end

    assign delta_o = all_vld_o ? (all_step_o - first_step_o) : '0;

    // R3: first-fail result frozen for the rest of the run
    a_r3_first_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld_o && !clear_i && !start_i) |=> (first_vld_o && $stable(first_step_o)));

    // R4: all-fail implies every pin flag is set and first-fail is recorded
    a_r4_all_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        all_vld_o |-> ((&mask_q) && first_vld_o));

    // R4: done state holds its result
    a_r4_done_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !clear_i && !start_i) |=> $stable(all_step_o));

    // R7: clear lands in idle with nothing recorded
    a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == ST_IDLE && !first_vld_o && !all_vld_o));

    // R6: no pin flag appears while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (mask_q == '0));
endmodule

// File: rtl/lb_fail_recorder.sv
module lb_fail_recorder #(
    parameter int unsigned NUM_GROUPS = 2,
    parameter int unsigned GROUP_W    = 8,
    parameter int unsigned STEP_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          clear_i,
    input  logic                          smp_valid,
    input  logic [STEP_W-1:0]             step_in,
    input  logic [NUM_GROUPS*GROUP_W-1:0] exp_bits,
    input  logic [NUM_GROUPS*GROUP_W-1:0] rcv_bits,
    output logic [NUM_GROUPS*GROUP_W-1:0] pin_fail,
    output logic [NUM_GROUPS-1:0]         first_vld,
    output logic [NUM_GROUPS*STEP_W-1:0]  first_step,
    output logic [NUM_GROUPS-1:0]         all_vld,
    output logic [NUM_GROUPS*STEP_W-1:0]  all_step,
    output logic [NUM_GROUPS*STEP_W-1:0]  fail_delta,
    output logic                          run_active
);
    localparam int unsigned PIN_TOTAL = NUM_GROUPS * GROUP_W;

    logic                  wipe;
    logic [NUM_GROUPS-1:0] busy;
    logic [NUM_GROUPS-1:0] cmp_en;
    logic [PIN_TOTAL-1:0]  mask_nx;

    assign wipe       = start_i | clear_i;
    assign run_active = |busy;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        lb_sticky #(.WIDTH(GROUP_W)) u_sticky (
            .clk      (clk),
            .rst_n    (rst_n),
            .wipe_i   (wipe),
            .cmp_en_i (cmp_en[g]),
            .exp_i    (exp_bits[g*GROUP_W +: GROUP_W]),
            .rcv_i    (rcv_bits[g*GROUP_W +: GROUP_W]),
            .mask_q   (pin_fail[g*GROUP_W +: GROUP_W]),
            .mask_nx  (mask_nx[g*GROUP_W +: GROUP_W])
        );

        lb_group_fsm #(.WIDTH(GROUP_W), .STEP_W(STEP_W)) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .start_i      (start_i),
            .clear_i      (clear_i),
            .smp_i        (smp_valid),
            .step_i       (step_in),
            .mask_q       (pin_fail[g*GROUP_W +: GROUP_W]),
            .mask_nx      (mask_nx[g*GROUP_W +: GROUP_W]),
            .cmp_en_o     (cmp_en[g]),
            .busy_o       (busy[g]),
            .first_vld_o  (first_vld[g]),
            .first_step_o (first_step[g*STEP_W +: STEP_W]),
            .all_vld_o    (all_vld[g]),
            .all_step_o   (all_step[g*STEP_W +: STEP_W]),
            .delta_o      (fail_delta[g*STEP_W +: STEP_W])
        );
    end

    // R8: start arms the block on the next cycle
    a_r8_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !clear_i) |=> (run_active && first_vld == '0 && all_vld == '0));

    // R5: without a full fail the difference reads zero
    a_r5_delta_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (all_vld == '0) |-> (fail_delta == '0));
endmodule

// File: tb/lb_fail_recorder_bench.sv
module lb_fail_recorder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        clear_i = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  step_in = '0;
    logic [15:0] exp_bits = '0;
    logic [15:0] rcv_bits = '0;
    logic [15:0] pin_fail;
    logic [1:0]  first_vld;
    logic [15:0] first_step;
    logic [1:0]  all_vld;
    logic [15:0] all_step;
    logic [15:0] fail_delta;
    logic        run_active;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lb_fail_recorder u_lb_fail_recorder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
        .smp_valid(smp_valid), .step_in(step_in), .exp_bits(exp_bits),
        .rcv_bits(rcv_bits), .pin_fail(pin_fail), .first_vld(first_vld),
        .first_step(first_step), .all_vld(all_vld), .all_step(all_step),
        .fail_delta(fail_delta), .run_active(run_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input logic v, input logic [7:0] st, input logic [15:0] e, input logic [15:0] r);
        smp_valid = v; step_in = st; exp_bits = e; rcv_bits = r;
        tick();
        smp_valid = 1'b0; exp_bits = '0; rcv_bits = '0;
    endtask

    task automatic do_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic do_clear();
        clear_i = 1'b1; tick(); clear_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 first_vld", first_vld, 0);
        chk("R1 all_vld", all_vld, 0);
        chk("R1 pin_fail", pin_fail, 0);
        chk("R1 steps", {first_step, all_step}, 0);
        chk("R1 run_active", run_active, 0);
    endtask

    task automatic t_ramp();
        do_start();
        chk("R8 run_active", run_active, 1);
        cyc(1, 8'd10, 16'h0000, 16'h0000);
        chk("R3 no fail yet", first_vld, 0);
        cyc(1, 8'd11, 16'h0000, 16'h0001);
        chk("R3 first_vld", first_vld, 2'b01);
        chk("R3 first_step g0", first_step[7:0], 8'd11);
        chk("R2 pin_fail", pin_fail, 16'h0001);
        cyc(1, 8'd12, 16'h0000, 16'h000E);
        chk("R3 first_step kept", first_step[7:0], 8'd11);
        chk("R2 accumulate", pin_fail, 16'h000F);
        chk("R5 delta before full", fail_delta[7:0], 0);
        cyc(1, 8'd13, 16'hAAAA, 16'hAA5A);
        chk("R4 all_vld", all_vld, 2'b01);
        chk("R4 all_step g0", all_step[7:0], 8'd13);
        chk("R5 delta g0", fail_delta[7:0], 8'd2);
        chk("R10 g1 untouched", {first_vld[1], pin_fail[15:8]}, 0);
        cyc(1, 8'd14, 16'h0000, 16'h00FF);
        chk("R4 done holds", all_step[7:0], 8'd13);
        chk("R4 first holds", first_step[7:0], 8'd11);
        cyc(1, 8'd20, 16'h0000, 16'hFF00);
        chk("R9 g1 first", first_step[15:8], 8'd20);
        chk("R9 g1 all", all_step[15:8], 8'd20);
        chk("R9 g1 delta", fail_delta[15:8], 0);
        chk("R10 g0 intact", {first_step[7:0], all_step[7:0]}, {8'd11, 8'd13});
        chk("R8 all done idle", run_active, 0);
    endtask

    task automatic t_ignore();
        do_start();
        cyc(0, 8'd5, 16'h0000, 16'hFFFF);
        chk("R6 smp low", {first_vld, pin_fail}, 0);
        do_clear();
        chk("R7 clear idle", run_active, 0);
        cyc(1, 8'd6, 16'h0000, 16'hFFFF);
        chk("R6 idle ignore", {first_vld, pin_fail}, 0);
    endtask

    task automatic t_partial();
        do_start();
        cyc(1, 8'd30, 16'h0000, 16'h0301);
        chk("R3 g0 first", first_step[7:0], 8'd30);
        chk("R3 g1 first", first_step[15:8], 8'd30);
        cyc(1, 8'd40, 16'h0000, 16'h7F00);
        chk("R5 partial no all", all_vld, 0);
        chk("R5 partial delta", fail_delta, 0);
        chk("R2 g1 mask", pin_fail[15:8], 8'h7F);
        start_i = 1'b1; clear_i = 1'b1; tick(); start_i = 1'b0; clear_i = 1'b0;
        chk("R7 clear wins", run_active, 0);
        chk("R7 results zero", {first_vld, pin_fail, first_step}, 0);
    endtask

    task automatic t_restart();
        do_start();
        cyc(1, 8'd50, 16'h0000, 16'h0010);
        chk("R3 before restart", first_vld, 2'b01);
        do_start();
        chk("R8 restart clears", {first_vld, pin_fail, first_step}, 0);
        chk("R8 rearmed", run_active, 1);
        cyc(1, 8'd60, 16'h0000, 16'h0002);
        chk("R3 new run", first_step[7:0], 8'd60);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        #6 rst_n = 1'b1;
        tick();
        t_reset();
        t_ramp();
        t_ignore();
        t_partial();
        t_restart();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule